// File: doc/BRIEF.md
# Windowed Branch Event Threshold Monitor

This block sits beside the retire stage of a processor core. It counts event pulses on two independent counters, for example branch mispredicts. When the counts reach programmed thresholds it raises a one-cycle trip pulse. It can also raise a sticky freeze line towards a branch trace recorder.

Counting is scoped by a window. Every retire strobe from a selectable source advances a window counter. When that counter reaches the programmed window size, the window restarts and both event counters are cleared.

Each counter has its own settings:
- an enable bit;
- a 7-bit threshold;
- a mode that either accumulates events over the window or counts only an unbroken run of events.

The two threshold results combine either by OR or by AND. In the AND combination a disabled counter is left out.

A global enable gates all counting. A guest-disable option suppresses counting and trips while the core reports guest execution.

Configuration arrives through a write-only register port. The port has three word addresses.

Top module: `retire_trip_monitor`

## Requirements
- R1: After reset, trip_o and freeze_o are low and the configuration holds these values:
  - global enable 0, freeze enable 0, guest disable 0, AND mode 0;
  - window source 00, window size 1023;
  - both counters disabled, accumulate mode, threshold 127.
- R2: The window source field selects which retire strobe advances the window: 00 instructions, 01 branches, 10 returns, 11 indirect branches. Strobes of the other sources do not advance it.
- R3: The window counter counts active strobes of the selected source. The strobe that brings the count to at least the window size clears the window and both event counters. A size of 0 behaves like a size of 1.
- R4: In accumulate mode (mode bit 0), an enabled counter adds one for each active event strobe. It saturates at 127 and never wraps.
- R5: In consecutive mode (mode bit 1), a strobe of the selected window source that arrives without an event strobe clears that counter. An event strobe in the same cycle increments the counter instead.
- R6: A counter meets its threshold when it is enabled and its count is greater than or equal to its threshold. With a threshold of 0, a trip follows every retired instruction.
- R7: With AND mode clear, a trip occurs when any enabled counter meets its threshold.
- R8: With AND mode set, a trip needs every enabled counter to meet its threshold. A disabled counter is ignored, and with no counter enabled no trip occurs.
- R9: A trip is evaluated only in a cycle with an instruction retire strobe. It appears on trip_o as a one-cycle pulse in the following cycle, and in the same edge it clears the window and both counters.
- R10: When freeze enable is set, a trip sets freeze_o, which then stays high. A write to address 0 with bit 31 set clears it. If a trip and a clearing write fall in the same cycle, the set wins.
- R11: With guest disable set and guest_i high, nothing is counted, the window does not advance and no trip occurs.
- R12: With global enable clear, no counting, window advance or trip occurs. A counter whose enable bit is clear does not count.
- R13: When a window clear and an event strobe fall in the same cycle, the clear wins and the event is lost.
- R14: Configuration writes take effect on the next cycle. The register map is:
  - address 0: bit 0 global enable, bit 1 freeze enable, bit 2 guest disable, bit 3 AND mode, bits 5:4 window source, bits 25:16 window size, bit 31 freeze clear (not stored);
  - address 1 (counter 0) and address 2 (counter 1): bit 0 enable, bit 1 consecutive mode, bits 14:8 threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ret_insn_i | input | 1 | Instruction retired this cycle |
| ret_branch_i | input | 1 | Branch retired this cycle |
| ret_return_i | input | 1 | Return retired this cycle |
| ret_indirect_i | input | 1 | Indirect branch retired this cycle |
| event_i | input | 2 | Event strobe per counter, bit i feeds counter i |
| guest_i | input | 1 | Core is executing in guest mode |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration word address |
| cfg_wdata_i | input | 32 | Configuration write data |
| trip_o | output | 1 | One-cycle trip pulse |
| freeze_o | output | 1 | Sticky freeze request for the trace recorder |

## Verification
The sharpest collision is a window expiry landing in the same cycle as an event strobe. The clear must win, so the event is lost and a later instruction finds the counter below its threshold. A directed case arranges this with a size-2 window advanced by branches. A second collision is a trip in the same cycle as a freeze-clearing write; a directed case drives both together and expects the freeze to stay set. Random runs with short windows, small thresholds and frequent reconfiguration make both collisions recur. Every cycle is judged against a cycle model written from the requirements.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
  localparam int WIN_W  = 10;
  localparam int THR_W  = 7;
  localparam int NCNT   = 2;
  localparam int CFG_DW = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    SRC_INSN     = 2'b00,
    SRC_BRANCH   = 2'b01,
    SRC_RETURN   = 2'b10,
    SRC_INDIRECT = 2'b11
  } win_src_e;

  typedef struct packed {
    logic             glb_en;
    logic             frz_en;
    logic             guest_dis;
    logic             and_mode;
    win_src_e         src;
    logic [WIN_W-1:0] win_size;
  } ctrl_t;

  typedef struct packed {
    logic             en;
    logic             consec;
    logic [THR_W-1:0] thr;
  } cnt_cfg_t;
endpackage

// File: rtl/rtm_cfg_regs.sv
module rtm_cfg_regs
  import rtm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [CFG_DW-1:0]      wdata_i,
  output ctrl_t                  ctrl_o,
  output cnt_cfg_t [NCNT-1:0]    cnt_cfg_o,
  output logic                   frz_clr_o
);
  ctrl_t ctrl_q, ctrl_d;
  logic  ctrl_we;

  assign ctrl_we   = we_i && (addr_i == '0);
  assign frz_clr_o = ctrl_we && wdata_i[31];

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) begin
      ctrl_d.glb_en    = wdata_i[0];
      ctrl_d.frz_en    = wdata_i[1];
      ctrl_d.guest_dis = wdata_i[2];
      ctrl_d.and_mode  = wdata_i[3];
      ctrl_d.src       = win_src_e'(wdata_i[5:4]);
      ctrl_d.win_size  = wdata_i[16 +: WIN_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.glb_en    <= 1'b0;
      ctrl_q.frz_en    <= 1'b0;
      ctrl_q.guest_dis <= 1'b0;
      ctrl_q.and_mode  <= 1'b0;
      ctrl_q.src       <= SRC_INSN;
      ctrl_q.win_size  <= {WIN_W{1'b1}};
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_d;
    end
  end
  assign ctrl_o = ctrl_q;

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt_reg
    cnt_cfg_t cc_q, cc_d;
    logic     cc_we;
    assign cc_we = we_i && (addr_i == ADDR_W'(i + 1));

    always_comb begin
      cc_d = cc_q;
      if (cc_we) begin
        cc_d.en     = wdata_i[0];
        cc_d.consec = wdata_i[1];
        cc_d.thr    = wdata_i[8 +: THR_W];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cc_q.en     <= 1'b0;
        cc_q.consec <= 1'b0;
        cc_q.thr    <= {THR_W{1'b1}};
      end else if (cc_we) begin
        cc_q <= cc_d;
      end
    end
    assign cnt_cfg_o[i] = cc_q;
  end

  logic unused_bits;
  assign unused_bits = ^{wdata_i[30:26], wdata_i[15], wdata_i[7:6]};
endmodule

// File: rtl/rtm_window.sv
module rtm_window
  import rtm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             clr_i,
  input  logic [WIN_W-1:0] size_i,
  output logic             expire_o
);
  logic [WIN_W-1:0] cnt_q, cnt_d;
  logic [WIN_W:0]   cnt_inc;

  assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
  assign expire_o = adv_i && (cnt_inc >= {1'b0, size_i});

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || expire_o) cnt_d = '0;
    else if (adv_i)        cnt_d = cnt_inc[WIN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_expire_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (cnt_q == '0));
endmodule

// File: rtl/rtm_evt_counter.sv
module rtm_evt_counter
  import rtm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  cnt_cfg_t         cfg_i,
  input  logic             ev_i,
  input  logic             src_stb_i,
  input  logic             clr_i,
  output logic             met_o
);
  localparam logic [THR_W-1:0] CNT_MAX = {THR_W{1'b1}};

  logic [THR_W-1:0] cnt_q, cnt_d;
  logic             live;

  assign live  = active_i && cfg_i.en;
  assign met_o = cfg_i.en && (cnt_q >= cfg_i.thr);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                                cnt_d = '0;
    else if (live && ev_i)                    cnt_d = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    else if (live && cfg_i.consec && src_stb_i) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_saturate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && live && ev_i && !clr_i) |=> (cnt_q == CNT_MAX));
  p_run_broken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && cfg_i.consec && src_stb_i && !ev_i && !clr_i) |=> (cnt_q == '0));
  p_clear_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/retire_trip_monitor.sv
module retire_trip_monitor
  import rtm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_insn_i,
  input  logic              ret_branch_i,
  input  logic              ret_return_i,
  input  logic              ret_indirect_i,
  input  logic [NCNT-1:0]   event_i,
  input  logic              guest_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CFG_DW-1:0] cfg_wdata_i,
  output logic              trip_o,
  output logic              freeze_o
);
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  ctrl_t               ctrl;
  cnt_cfg_t [NCNT-1:0] cnt_cfg;
  logic                frz_clr;

  rtm_cfg_regs i_cfg (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .ctrl_o    (ctrl),
    .cnt_cfg_o (cnt_cfg),
    .frz_clr_o (frz_clr)
  );

  logic       active, src_stb, win_expire, trip_cond, clr_all;
  logic [3:0] stb_vec;
  logic [NCNT-1:0] met;

  assign active  = ctrl.glb_en && !(ctrl.guest_dis && guest_i);
  assign stb_vec = {ret_indirect_i, ret_return_i, ret_branch_i, ret_insn_i};
  assign src_stb = stb_vec[ctrl.src];

  rtm_window i_win (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .adv_i    (active && src_stb),
    .clr_i    (trip_cond),
    .size_i   (ctrl.win_size),
    .expire_o (win_expire)
  );

  for (genvar i = 0; i < NCNT; i++) begin : g_cnt
    rtm_evt_counter i_cnt (
      .clk       (clk),
      .rst_n     (rst_s_n),
      .active_i  (active),
      .cfg_i     (cnt_cfg[i]),
      .ev_i      (event_i[i]),
      .src_stb_i (src_stb),
      .clr_i     (clr_all),
      .met_o     (met[i])
    );
  end

  logic any_en, all_ok, any_met, combined;
  always_comb begin
    any_en  = 1'b0;
    all_ok  = 1'b1;
    any_met = 1'b0;
    for (int i = 0; i < NCNT; i++) begin
      any_en  = any_en  | cnt_cfg[i].en;
      all_ok  = all_ok  & (!cnt_cfg[i].en | met[i]);
      any_met = any_met | met[i];
    end
    combined = ctrl.and_mode ? (any_en && all_ok) : any_met;
  end

  assign trip_cond = active && ret_insn_i && combined;
  assign clr_all   = trip_cond || win_expire;

  logic trip_q, trip_d, frz_q, frz_d;
  always_comb begin
    trip_d = trip_cond;
    frz_d  = frz_q;
    if (trip_cond && ctrl.frz_en) frz_d = 1'b1;
    else if (frz_clr)             frz_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      trip_q <= 1'b0;
      frz_q  <= 1'b0;
    end else begin
      trip_q <= trip_d;
      frz_q  <= frz_d;
    end
  end

  assign trip_o   = trip_q;
  assign freeze_o = frz_q;

  p_trip_on_retire_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    trip_o |-> $past(ret_insn_i));
  p_freeze_sticky_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (freeze_o && !(cfg_we_i && cfg_addr_i == '0 && cfg_wdata_i[31])) |=> freeze_o);
  p_guest_quiet_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ctrl.guest_dis && guest_i) |=> !trip_o);
  p_global_gate_r12: assert property (@(posedge clk) disable iff (!rst_s_n)
    !ctrl.glb_en |=> !trip_o);
endmodule

// File: tb/test_retire_trip_monitor.sv
module test_retire_trip_monitor;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ret_insn, ret_br, ret_ret, ret_ind, guest, cfg_we;
  logic [1:0]  ev, cfg_addr;
  logic [31:0] cfg_wdata;
  logic        trip_o, freeze_o;

  always #10 clk = ~clk;

  retire_trip_monitor i_retire_trip_monitor (
    .clk(clk), .rst_n(rst_n), .ret_insn_i(ret_insn), .ret_branch_i(ret_br),
    .ret_return_i(ret_ret), .ret_indirect_i(ret_ind), .event_i(ev),
    .guest_i(guest), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .trip_o(trip_o), .freeze_o(freeze_o));

  int nvec = 0, nfail = 0;
  // cycle model state, from the requirements
  bit m_glb, m_frzen, m_gdis, m_and, m_trip, m_frz;
  int m_src, m_size, m_win;
  bit m_en [2], m_cons [2];
  int m_thr [2], m_cnt [2];

  task automatic model_reset();
    m_glb = 0; m_frzen = 0; m_gdis = 0; m_and = 0; m_src = 0; m_size = 1023;
    m_win = 0; m_trip = 0; m_frz = 0;
    for (int i = 0; i < 2; i++) begin m_en[i] = 0; m_cons[i] = 0; m_thr[i] = 127; m_cnt[i] = 0; end
  endtask

  function automatic bit stb_of(int s);
    bit [3:0] v = {ret_ind, ret_ret, ret_br, ret_insn};
    return v[s];
  endfunction

  task automatic model_step();
    bit act, s, anyen, allok, anymet, comb, trip, adv, expire;
    bit met [2];
    act = m_glb && !(m_gdis && guest);
    s = stb_of(m_src);
    anyen = 0; allok = 1; anymet = 0;
    for (int i = 0; i < 2; i++) begin
      met[i] = m_en[i] && (m_cnt[i] >= m_thr[i]);
      anyen |= m_en[i]; allok &= (!m_en[i] || met[i]); anymet |= met[i];
    end
    comb = m_and ? (anyen && allok) : anymet;
    trip = act && ret_insn && comb;
    adv = act && s;
    expire = adv && (m_win + 1 >= m_size);
    if (trip || expire) m_win = 0; else if (adv) m_win = m_win + 1;
    for (int i = 0; i < 2; i++) begin
      if (trip || expire) m_cnt[i] = 0;
      else if (act && m_en[i] && ev[i]) m_cnt[i] = (m_cnt[i] >= 127) ? 127 : m_cnt[i] + 1;
      else if (act && m_en[i] && m_cons[i] && s) m_cnt[i] = 0;
    end
    m_trip = trip;
    if (trip && m_frzen) m_frz = 1;
    else if (cfg_we && cfg_addr == 0 && cfg_wdata[31]) m_frz = 0;
    if (cfg_we && cfg_addr == 0) begin
      m_glb = cfg_wdata[0]; m_frzen = cfg_wdata[1]; m_gdis = cfg_wdata[2];
      m_and = cfg_wdata[3]; m_src = int'(cfg_wdata[5:4]); m_size = int'(cfg_wdata[25:16]);
    end else if (cfg_we && (cfg_addr == 1 || cfg_addr == 2)) begin
      m_en[cfg_addr-1] = cfg_wdata[0]; m_cons[cfg_addr-1] = cfg_wdata[1];
      m_thr[cfg_addr-1] = int'(cfg_wdata[14:8]);
    end
  endtask

  task automatic cmp(input string tag, input string what, input logic got, input logic exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic idle();
    ret_insn = 0; ret_br = 0; ret_ret = 0; ret_ind = 0; ev = 0; guest = 0;
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
  endtask

  task automatic tick(input string tag);
    model_step();
    @(negedge clk);
    cmp(tag, "trip", trip_o, m_trip);
    cmp("R10", "freeze", freeze_o, m_frz);
    idle();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    tick(tag);
  endtask

  task automatic insn_expect(input string tag, input bit e);
    ret_insn = 1; tick(tag); cmp(tag, "trip", trip_o, e);
  endtask

  initial begin
    void'($urandom(32'h1BADF00D));
    idle(); rst_n = 0; model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    cmp("R1", "trip", trip_o, 1'b0);
    cmp("R1", "freeze", freeze_o, 1'b0);
    // R1: counters disabled at reset, so enabling globally gives no trip
    wr(0, 32'h03FF0001, "R1");
    insn_expect("R1", 0);
    // R12: global enable gate
    wr(0, 32'h03FF0000, "R12");
    wr(1, 32'h00000001, "R12");
    insn_expect("R12", 0);
    wr(0, 32'h03FF0001, "R14");
    insn_expect("R6", 1);
    tick("R9"); cmp("R9", "trip", trip_o, 0);
    insn_expect("R6", 1);
    // R7 / R8 combine
    wr(2, 32'h00000301, "R7");
    insn_expect("R7", 1);
    wr(0, 32'h03FF0009, "R8");
    insn_expect("R8", 0);
    repeat (3) begin ev = 2'b10; tick("R8"); end
    insn_expect("R8", 1);
    wr(2, 32'h00000300, "R8");
    insn_expect("R8", 1);
    wr(1, 32'h00000000, "R8");
    insn_expect("R8", 0);
    // R5 consecutive mode
    wr(0, 32'h03FF0001, "R5");
    wr(1, 32'h00000203, "R5");
    ev = 2'b01; tick("R5");
    insn_expect("R5", 0);
    ev = 2'b01; tick("R5");
    ev = 2'b01; insn_expect("R5", 0);
    insn_expect("R5", 1);
    // R2 / R3 window by branches, size 2
    wr(1, 32'h00000201, "R3");
    wr(0, 32'h00020011, "R2");
    ev = 2'b01; tick("R3");
    ret_br = 1; tick("R3");
    ret_br = 1; tick("R3");
    ev = 2'b01; tick("R3");
    insn_expect("R3", 0);
    ev = 2'b01; tick("R3");
    insn_expect("R3", 1);
    ev = 2'b01; tick("R2");
    insn_expect("R2", 0);
    insn_expect("R2", 0);
    ev = 2'b01; tick("R2");
    insn_expect("R2", 1);
    // R13 expiry and event in the same cycle
    wr(1, 32'h00000101, "R13");
    ret_br = 1; tick("R13");
    ret_br = 1; ev = 2'b01; tick("R13");
    insn_expect("R13", 0);
    // R11 guest disable
    wr(1, 32'h00000001, "R11");
    wr(0, 32'h03FF0005, "R11");
    guest = 1; insn_expect("R11", 0);
    guest = 0; insn_expect("R11", 1);
    // R10 freeze
    wr(0, 32'h03FF0003, "R10");
    insn_expect("R10", 1); cmp("R10", "freeze", freeze_o, 1);
    repeat (3) tick("R10");
    cmp("R10", "freeze", freeze_o, 1);
    wr(0, 32'h83FF0003, "R10"); cmp("R10", "freeze", freeze_o, 0);
    ret_insn = 1; wr(0, 32'h83FF0003, "R10"); cmp("R10", "freeze", freeze_o, 1);
    wr(0, 32'h83FF0001, "R10");
    // R4 saturation: 200 events, no window advance
    wr(0, 32'h03FF0011, "R4");
    wr(1, 32'h00007F01, "R4");
    repeat (200) begin ev = 2'b01; tick("R4"); end
    insn_expect("R4", 1);
    // constrained random
    for (int n = 0; n < 20000; n++) begin
      if ($urandom_range(99) < 3) begin
        cfg_we = 1; cfg_addr = 2'($urandom_range(2));
        if (cfg_addr == 0)
          cfg_wdata = {1'($urandom_range(9) == 0), 5'd0, 10'($urandom_range(12)), 10'd0,
                       2'($urandom), 1'($urandom), 1'($urandom_range(3) == 0),
                       1'($urandom), 1'($urandom_range(9) != 0)};
        else
          cfg_wdata = {17'd0, 7'($urandom_range(6)), 6'd0, 1'($urandom), 1'($urandom_range(3) != 0)};
      end
      ret_insn = 1'($urandom); ret_br = 1'($urandom); ret_ret = 1'($urandom);
      ret_ind = 1'($urandom); ev = 2'($urandom); guest = ($urandom_range(3) == 0);
      tick("R9");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule